// File: doc/BRIEF.md
# SPI Word/Unit Packer with FIFO Threshold Flags

This block sits between a 32-bit register port and the bit shifter of a serial peripheral controller. Words written from the register side go into a small transmit FIFO and leave it as data units on a valid/ready port towards the shifter. Units arriving from the shifter go into a receive FIFO and are read back as words. The width of a unit is programmable from 1 to 32 bits. When units are exactly one byte wide, an optional packing mode splits each written word into four bytes and gathers four received bytes into one word.

Both FIFO fill levels are compared with programmable thresholds. The transmit side raises its flag when the FIFO runs low, and the receive side raises its flag when the FIFO fills up. Each flag is a sticky status bit that is cleared by writing one, and each drives an interrupt line through its own enable. During an active transfer, a register access that cannot complete holds the bus through a stall output. Outside a transfer, such an access completes at once without effect. Each FIFO has a flush request that empties it and clears itself again.

Top module: `spi_unit_packer`

## Requirements
- R1: The unit width is `unitLenM1`+1 bits. With packing off, a written word leaves as a single unit holding only its low unit-width bits, and a received unit is read back with every bit above the unit width cleared.
- R2: Packing is in effect only when `mergeEn`=1 and `unitLenM1`=7. With any other width, each written word leaves as exactly one unit.
- R3: With packing in effect, a written word leaves as four 8-bit units, bits [7:0] first and bits [31:24] last, with unit bits [31:8] at zero.
- R4: With packing in effect, four received bytes form one word, the first byte in bits [7:0]. A word is not readable until its fourth byte has arrived.
- R5: Status bit 0 (transmit) sets on every cycle in which the transmit entry count is less than or equal to `txThresh`.
- R6: Status bit 1 (receive) sets on every cycle in which the receive entry count is greater than or equal to `rxThresh`.
- R7: A status bit stays set until it is cleared by a pulse on `intClrEn` with the matching `intClrMask` bit at 1, and it sets again while its condition still holds. `irq[i]` is high only when `intStatus[i]` and `intEnable[i]` are both 1.
- R8: While `xferActive`=1, `stall` is high during a write to a full transmit FIFO and during a read from an empty receive FIFO, and the stalled access has no effect.
- R9: While `xferActive`=0, `stall` stays low. A write to a full transmit FIFO is discarded, and a read from an empty receive FIFO returns zero.
- R10: A pulse on a flush request sets that FIFO's busy bit for one cycle. At the end of that cycle the FIFO and its partial pack state are empty, and the busy bit clears itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferActive | input | 1 | A serial transfer is in progress; enables stalling |
| unitLenM1 | input | 5 | Unit width minus one |
| mergeEn | input | 1 | Request byte packing (effective only at 8-bit units) |
| txThresh | input | CW (3) | Transmit low-level threshold |
| rxThresh | input | CW (3) | Receive high-level threshold |
| intEnable | input | 2 | Interrupt enables: bit 0 transmit, bit 1 receive |
| intClrEn | input | 1 | Strobe for write-one-to-clear of status |
| intClrMask | input | 2 | Status bits to clear when `intClrEn` is high |
| txFlushReq | input | 1 | Request to empty the transmit FIFO |
| rxFlushReq | input | 1 | Request to empty the receive FIFO |
| txFlushBusy | output | 1 | Transmit flush in progress (self-clearing) |
| rxFlushBusy | output | 1 | Receive flush in progress (self-clearing) |
| regWrEn | input | 1 | Register write of a data word |
| regWrData | input | 32 | Word written |
| regRdEn | input | 1 | Register read of a data word |
| regRdData | output | 32 | Word read (zero when nothing is popped) |
| stall | output | 1 | Register access must wait |
| intStatus | output | 2 | Sticky threshold status: bit 0 transmit, bit 1 receive |
| irq | output | 2 | Enabled interrupt lines |
| txUnitValid | output | 1 | Transmit unit available to the shifter |
| txUnitReady | input | 1 | Shifter accepts the transmit unit |
| txUnitData | output | 32 | Transmit unit, right-aligned |
| rxUnitValid | input | 1 | Shifter offers a received unit |
| rxUnitReady | output | 1 | Packer accepts the received unit |
| rxUnitData | input | 32 | Received unit, right-aligned |

## Verification
The hardest states to reach from the ports are the transmit threshold boundary and the stall. For the boundary, the shifter side has to be held off so that the transmit FIFO stays above the threshold, and then released one unit at a time, so that the status bit is observed just before and just after the count reaches the threshold. The bench does this by pulsing `txUnitReady` for single cycles. For the stall, the transmit FIFO is filled to depth with the shifter stalled, and only then is `xferActive` raised for one more write. The same full FIFO is then reused with `xferActive` low. Draining it afterwards proves that the extra word was dropped.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;
  // Strobes from control to datapath, one per cycle
  typedef struct packed {
    logic txPush;   // accept regWrData into the transmit FIFO
    logic rxPop;    // pop receive FIFO onto regRdData
    logic txFlush;  // empty transmit FIFO and split state
    logic rxFlush;  // empty receive FIFO and gather state
    logic merge;    // byte packing in effect
  } packStrobe_t;
endpackage

// File: rtl/spi_pack_fifo.sv
module spi_pack_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  pushData,
  input  logic          pop,
  output logic [W-1:0]  popData,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/spi_pack_ctrl.sv
module spi_pack_ctrl
  import spi_pack_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          xferActive,
  input  logic [4:0]    unitLenM1,
  input  logic          mergeEn,
  input  logic [CW-1:0] txThresh,
  input  logic [CW-1:0] rxThresh,
  input  logic [1:0]    intEnable,
  input  logic          intClrEn,
  input  logic [1:0]    intClrMask,
  input  logic          txFlushReq,
  input  logic          rxFlushReq,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic          txFull,
  input  logic [CW-1:0] txCount,
  input  logic          rxEmpty,
  input  logic [CW-1:0] rxCount,
  output packStrobe_t   strobe,
  output logic          stall,
  output logic [1:0]    intStatus,
  output logic [1:0]    irq,
  output logic          txFlushBusy,
  output logic          rxFlushBusy
);
  logic [1:0] cond;
  logic [1:0] clrBits;

  assign strobe.merge   = mergeEn && (unitLenM1 == 5'd7);
  assign strobe.txFlush = txFlushBusy;
  assign strobe.rxFlush = rxFlushBusy;
  assign strobe.txPush  = regWrEn && !txFull && !txFlushBusy;
  assign strobe.rxPop   = regRdEn && !rxEmpty && !rxFlushBusy;

  assign stall = xferActive && ((regWrEn && txFull) || (regRdEn && rxEmpty));

  // transmit flags when running low, receive when filling up
  assign cond[0] = (txCount <= txThresh);
  assign cond[1] = (rxCount >= rxThresh);
  assign clrBits = intClrEn ? intClrMask : 2'b00;
  assign irq     = intStatus & intEnable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intStatus   <= '0;
      txFlushBusy <= 1'b0;
      rxFlushBusy <= 1'b0;
    end else begin
      intStatus   <= (intStatus & ~clrBits) | cond;
      txFlushBusy <= txFlushReq;
      rxFlushBusy <= rxFlushReq;
    end
  end
endmodule

// File: rtl/spi_pack_dpath.sv
module spi_pack_dpath
  import spi_pack_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  packStrobe_t   strobe,
  input  logic [4:0]    unitLenM1,
  input  logic [31:0]   regWrData,
  output logic [31:0]   regRdData,
  output logic          txFull,
  output logic [CW-1:0] txCount,
  output logic          rxEmpty,
  output logic [CW-1:0] rxCount,
  output logic          txUnitValid,
  input  logic          txUnitReady,
  output logic [31:0]   txUnitData,
  input  logic          rxUnitValid,
  output logic          rxUnitReady,
  input  logic [31:0]   rxUnitData
);
  logic [31:0] unitMask;
  logic [31:0] txHead, rxHead, rxPushData;
  logic        txEmpty, rxFull, txFire, rxFire, txPop, rxPush;
  logic [1:0]  txByteIdx, rxByteIdx;
  logic [23:0] rxAcc;

  assign unitMask = 32'hFFFF_FFFF >> (5'd31 - unitLenM1);

  spi_pack_fifo #(.W(32), .DEPTH(DEPTH), .CW(CW)) uTxFifo (
    .clk(clk), .rstN(rstN), .flush(strobe.txFlush),
    .push(strobe.txPush), .pushData(regWrData),
    .pop(txPop), .popData(txHead),
    .count(txCount), .full(txFull), .empty(txEmpty)
  );

  spi_pack_fifo #(.W(32), .DEPTH(DEPTH), .CW(CW)) uRxFifo (
    .clk(clk), .rstN(rstN), .flush(strobe.rxFlush),
    .push(rxPush), .pushData(rxPushData),
    .pop(strobe.rxPop), .popData(rxHead),
    .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  // transmit split: one unit per word, or four bytes low byte first
  assign txUnitValid = !txEmpty && !strobe.txFlush;
  assign txUnitData  = strobe.merge ? {24'b0, txHead[{txByteIdx, 3'b000} +: 8]}
                                    : (txHead & unitMask);
  assign txFire = txUnitValid && txUnitReady;
  assign txPop  = txFire && (!strobe.merge || txByteIdx == 2'd3);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.txFlush) txByteIdx <= '0;
    else if (txFire)             txByteIdx <= strobe.merge ? txByteIdx + 1'b1 : 2'd0;
  end

  // receive gather: a word is pushed only with its fourth byte
  assign rxUnitReady = !rxFull && !strobe.rxFlush;
  assign rxFire      = rxUnitValid && rxUnitReady;
  assign rxPush      = rxFire && (!strobe.merge || rxByteIdx == 2'd3);
  assign rxPushData  = strobe.merge ? {rxUnitData[7:0], rxAcc}
                                    : (rxUnitData & unitMask);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.rxFlush) begin
      rxByteIdx <= '0;
      rxAcc     <= '0;
    end else if (rxFire) begin
      if (strobe.merge) begin
        rxByteIdx <= rxByteIdx + 1'b1;
        case (rxByteIdx)
          2'd0:    rxAcc[7:0]   <= rxUnitData[7:0];
          2'd1:    rxAcc[15:8]  <= rxUnitData[7:0];
          2'd2:    rxAcc[23:16] <= rxUnitData[7:0];
          default: rxAcc        <= rxAcc;
        endcase
      end else begin
        rxByteIdx <= '0;
      end
    end
  end

  assign regRdData = strobe.rxPop ? rxHead : '0;
endmodule

// File: rtl/spi_unit_packer.sv
module spi_unit_packer
  import spi_pack_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          xferActive,
  input  logic [4:0]    unitLenM1,
  input  logic          mergeEn,
  input  logic [CW-1:0] txThresh,
  input  logic [CW-1:0] rxThresh,
  input  logic [1:0]    intEnable,
  input  logic          intClrEn,
  input  logic [1:0]    intClrMask,
  input  logic          txFlushReq,
  input  logic          rxFlushReq,
  output logic          txFlushBusy,
  output logic          rxFlushBusy,
  input  logic          regWrEn,
  input  logic [31:0]   regWrData,
  input  logic          regRdEn,
  output logic [31:0]   regRdData,
  output logic          stall,
  output logic [1:0]    intStatus,
  output logic [1:0]    irq,
  output logic          txUnitValid,
  input  logic          txUnitReady,
  output logic [31:0]   txUnitData,
  input  logic          rxUnitValid,
  output logic          rxUnitReady,
  input  logic [31:0]   rxUnitData
);
  packStrobe_t   strobe;
  logic          txFull, rxEmpty;
  logic [CW-1:0] txCount, rxCount;

  spi_pack_ctrl #(.CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN), .xferActive(xferActive),
    .unitLenM1(unitLenM1), .mergeEn(mergeEn),
    .txThresh(txThresh), .rxThresh(rxThresh),
    .intEnable(intEnable), .intClrEn(intClrEn), .intClrMask(intClrMask),
    .txFlushReq(txFlushReq), .rxFlushReq(rxFlushReq),
    .regWrEn(regWrEn), .regRdEn(regRdEn),
    .txFull(txFull), .txCount(txCount), .rxEmpty(rxEmpty), .rxCount(rxCount),
    .strobe(strobe), .stall(stall), .intStatus(intStatus), .irq(irq),
    .txFlushBusy(txFlushBusy), .rxFlushBusy(rxFlushBusy)
  );

  spi_pack_dpath #(.DEPTH(DEPTH), .CW(CW)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .unitLenM1(unitLenM1),
    .regWrData(regWrData), .regRdData(regRdData),
    .txFull(txFull), .txCount(txCount), .rxEmpty(rxEmpty), .rxCount(rxCount),
    .txUnitValid(txUnitValid), .txUnitReady(txUnitReady), .txUnitData(txUnitData),
    .rxUnitValid(rxUnitValid), .rxUnitReady(rxUnitReady), .rxUnitData(rxUnitData)
  );
endmodule

// File: rtl/spi_pack_checker.sv
module spi_pack_checker (
  input logic        clk,
  input logic        rstN,
  input logic        xferActive,
  input logic [4:0]  unitLenM1,
  input logic        mergeEn,
  input logic [1:0]  intEnable,
  input logic [1:0]  intStatus,
  input logic [1:0]  irq,
  input logic        txFlushReq,
  input logic        txFlushBusy,
  input logic        rxFlushReq,
  input logic        rxFlushBusy,
  input logic        regWrEn,
  input logic        regRdEn,
  input logic        stall,
  input logic        txUnitValid,
  input logic [31:0] txUnitData
);
  logic packOn;
  assign packOn = mergeEn && (unitLenM1 == 5'd7);

  a_r1_unit_width: assert property (@(posedge clk) disable iff (!rstN)
    (txUnitValid && !packOn && unitLenM1 != 5'd31)
      |-> ((txUnitData >> ({1'b0, unitLenM1} + 6'd1)) == 32'd0));

  a_r3_byte_units: assert property (@(posedge clk) disable iff (!rstN)
    (txUnitValid && packOn) |-> (txUnitData[31:8] == 24'd0));

  a_r7_irq_tx_gated: assert property (@(posedge clk) disable iff (!rstN)
    irq[0] |-> (intEnable[0] && intStatus[0]));

  a_r7_irq_rx_gated: assert property (@(posedge clk) disable iff (!rstN)
    irq[1] |-> (intEnable[1] && intStatus[1]));

  a_r8_stall_cause: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (xferActive && (regWrEn || regRdEn)));

  a_r9_idle_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    !xferActive |-> !stall);

  a_r10_tx_selfclear: assert property (@(posedge clk) disable iff (!rstN)
    (txFlushBusy && !txFlushReq) |=> !txFlushBusy);

  a_r10_rx_selfclear: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlushBusy && !rxFlushReq) |=> !rxFlushBusy);

  a_r10_tx_emptied: assert property (@(posedge clk) disable iff (!rstN)
    txFlushBusy |=> !txUnitValid);
endmodule

bind spi_unit_packer spi_pack_checker uChecker (.*);

// File: tb/tb_spi_unit_packer.sv
`timescale 1ns/1ps
module tb_spi_unit_packer;
  localparam int DEPTH = 4;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xferActive = 1'b0;
  logic [4:0] unitLenM1 = 5'd7;
  logic mergeEn = 1'b0;
  logic [CW-1:0] txThresh = CW'(1);
  logic [CW-1:0] rxThresh = CW'(2);
  logic [1:0] intEnable = 2'b00;
  logic intClrEn = 1'b0;
  logic [1:0] intClrMask = 2'b00;
  logic txFlushReq = 1'b0, rxFlushReq = 1'b0;
  logic txFlushBusy, rxFlushBusy;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic stall;
  logic [1:0] intStatus, irq;
  logic txUnitValid;
  logic txUnitReady = 1'b0;
  logic [31:0] txUnitData;
  logic rxUnitValid = 1'b0;
  logic rxUnitReady;
  logic [31:0] rxUnitData = '0;

  int total = 0;
  int failed = 0;
  string txReq = "R1";
  logic [31:0] txExp[$];
  logic [31:0] rdVal;
  logic rdStall;

  always #10 clk = ~clk;

  spi_unit_packer #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // expected transmit units for one accepted word, from the requirements
  task automatic expectWord(input logic [31:0] w);
    if (mergeEn && unitLenM1 == 5'd7) begin
      for (int b = 0; b < 4; b++) txExp.push_back({24'b0, w[8*b +: 8]});
    end else begin
      txExp.push_back(w & (32'hFFFF_FFFF >> (31 - unitLenM1)));
    end
  endtask

  task automatic doWrite(input logic [31:0] w, input bit accepted);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = w;
    if (accepted) expectWord(w);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doRead(output logic [31:0] d, output logic s);
    @(negedge clk);
    regRdEn = 1'b1;
    #1;
    d = regRdData;
    s = stall;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic sendUnit(input logic [31:0] u);
    @(negedge clk);
    rxUnitValid = 1'b1;
    rxUnitData = u;
    @(negedge clk);
    rxUnitValid = 1'b0;
  endtask

  task automatic clearStatus(input logic [1:0] m);
    @(negedge clk);
    intClrEn = 1'b1;
    intClrMask = m;
    @(negedge clk);
    intClrEn = 1'b0;
  endtask

  task automatic drainOne();
    @(negedge clk);
    txUnitReady = 1'b1;
    @(negedge clk);
    txUnitReady = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor on the transmit unit port
  always @(negedge clk) begin
    #1;
    if (rstN && txUnitValid && txUnitReady) begin
      if (txExp.size() == 0) chk({txReq, " unexpected unit"}, txUnitData, 32'hDEAD_BEEF);
      else chk(txReq, txUnitData, txExp.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failed++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    idle(3);
    #1;
    chk("R5 reset status", {30'b0, intStatus}, 32'd0);
    chk("R10 reset tx valid", {31'b0, txUnitValid}, 32'd0);
    chk("R8 reset stall", {31'b0, stall}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: 12-bit units, packing off
    txReq = "R1";
    unitLenM1 = 5'd11;
    txUnitReady = 1'b1;
    doWrite(32'hABCD_E123, 1'b1);
    doWrite(32'h0000_0FFF, 1'b1);
    idle(6);

    // R3: byte packing, low byte first
    txReq = "R3";
    unitLenM1 = 5'd7;
    mergeEn = 1'b1;
    doWrite(32'h1122_3344, 1'b1);
    doWrite(32'hA5B6_C7D8, 1'b1);
    idle(12);

    // R2: packing requested at 16-bit width has no effect
    txReq = "R2";
    unitLenM1 = 5'd15;
    doWrite(32'h1234_5678, 1'b1);
    idle(6);
    chk("R2 no extra units", {31'b0, txUnitValid}, 32'd0);
    chk("R2 queue drained", txExp.size(), 32'd0);

    // R5/R7: transmit threshold boundary
    txReq = "R5";
    txUnitReady = 1'b0;
    unitLenM1 = 5'd7;
    mergeEn = 1'b0;
    doWrite(32'h01, 1'b1);
    doWrite(32'h02, 1'b1);
    doWrite(32'h03, 1'b1);
    clearStatus(2'b01);
    idle(2);
    chk("R5 above threshold", {31'b0, intStatus[0]}, 32'd0);
    intEnable = 2'b01;
    idle(1);
    chk("R7 irq off with status 0", {31'b0, irq[0]}, 32'd0);
    drainOne();
    idle(2);
    chk("R5 count 2 > 1", {31'b0, intStatus[0]}, 32'd0);
    drainOne();
    idle(2);
    chk("R5 count 1 <= 1", {31'b0, intStatus[0]}, 32'd1);
    chk("R7 irq enabled", {31'b0, irq[0]}, 32'd1);
    intEnable = 2'b00;
    idle(1);
    chk("R7 irq masked", {31'b0, irq[0]}, 32'd0);
    clearStatus(2'b01);
    idle(2);
    chk("R7 resets while condition holds", {31'b0, intStatus[0]}, 32'd1);
    txUnitReady = 1'b1;
    idle(4);
    txUnitReady = 1'b0;

    // R6/R1: receive threshold, masked units
    clearStatus(2'b10);
    sendUnit(32'h0000_01AB);
    idle(2);
    chk("R6 count 1 < 2", {31'b0, intStatus[1]}, 32'd0);
    sendUnit(32'hFFFF_F0CD);
    idle(2);
    chk("R6 count 2 >= 2", {31'b0, intStatus[1]}, 32'd1);
    doRead(rdVal, rdStall);
    chk("R1 rx masked first", rdVal, 32'h0000_00AB);
    doRead(rdVal, rdStall);
    chk("R1 rx masked second", rdVal, 32'h0000_00CD);
    clearStatus(2'b10);
    idle(2);
    chk("R7 w1c receive", {31'b0, intStatus[1]}, 32'd0);

    // R4: gather, partial word hidden
    mergeEn = 1'b1;
    sendUnit(32'h10);
    sendUnit(32'h20);
    sendUnit(32'h30);
    idle(2);
    doRead(rdVal, rdStall);
    chk("R4 partial word not readable", rdVal, 32'd0);
    sendUnit(32'h40);
    idle(1);
    doRead(rdVal, rdStall);
    chk("R4 gathered word", rdVal, 32'h4030_2010);
    mergeEn = 1'b0;

    // R8/R9 transmit: full FIFO
    txReq = "R9";
    for (int i = 0; i < DEPTH; i++) doWrite(32'h50 + i, 1'b1);
    xferActive = 1'b1;
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = 32'h99;
    #1;
    chk("R8 stall on full write", {31'b0, stall}, 32'd1);
    @(negedge clk);
    regWrEn = 1'b0;
    xferActive = 1'b0;
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = 32'h77;
    #1;
    chk("R9 no stall when idle", {31'b0, stall}, 32'd0);
    @(negedge clk);
    regWrEn = 1'b0;
    txUnitReady = 1'b1;
    idle(10);
    chk("R9 dropped write not sent", {31'b0, txUnitValid}, 32'd0);
    chk("R8 R9 all expected units seen", txExp.size(), 32'd0);
    txUnitReady = 1'b0;

    // R8/R9 receive: empty FIFO
    xferActive = 1'b1;
    @(negedge clk);
    regRdEn = 1'b1;
    #1;
    chk("R8 stall on empty read", {31'b0, stall}, 32'd1);
    @(negedge clk);
    regRdEn = 1'b0;
    xferActive = 1'b0;
    doRead(rdVal, rdStall);
    chk("R9 empty read data", rdVal, 32'd0);
    chk("R9 empty read stall", {31'b0, rdStall}, 32'd0);

    // R10: flush both FIFOs
    doWrite(32'hAA, 1'b0);
    doWrite(32'hBB, 1'b0);
    @(negedge clk);
    txFlushReq = 1'b1;
    @(negedge clk);
    txFlushReq = 1'b0;
    #1;
    chk("R10 tx busy set", {31'b0, txFlushBusy}, 32'd1);
    @(negedge clk);
    #1;
    chk("R10 tx busy cleared", {31'b0, txFlushBusy}, 32'd0);
    chk("R10 tx emptied", {31'b0, txUnitValid}, 32'd0);
    sendUnit(32'h5A);
    @(negedge clk);
    rxFlushReq = 1'b1;
    @(negedge clk);
    rxFlushReq = 1'b0;
    #1;
    chk("R10 rx busy set", {31'b0, rxFlushBusy}, 32'd1);
    idle(1);
    doRead(rdVal, rdStall);
    chk("R10 rx emptied", rdVal, 32'd0);
    chk("R10 rx busy self-cleared", {31'b0, rxFlushBusy}, 32'd0);

    idle(3);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule